// File: doc/BRIEF.md
# Twelve-Pin GPIO Controller with Latched Level Interrupts

This block gives software control of twelve general-purpose pins over a small 32-bit register bus. One address (`bus_addr`) selects the register, and a write strobe (`bus_we`) with write data updates it on the rising clock edge. Read data is a combinational function of the address. Software can set an output value and an output enable for each pin. It can also read each pad's level after a two-flop synchronizer.

Each pin can raise a level-sensitive interrupt, and the polarity of each pin is set in software. While a pin sits at its active level, its status bit latches. The bit stays set until software writes a one to it. If the pin is still active when the bit is cleared, the bit sets again one cycle later. A per-pin enable register gates the status bits onto one combined interrupt line. A 32-bit mux-control word is stored and driven straight out of the block.

Top module: `gpio12_ctrl`

## Requirements
- R1: After reset, every register reads zero while the pads are low: output data, output enable, interrupt enable, status, both type words and mux control. The outputs `pad_out`, `pad_oe`, `mux_ctl` and `irq` are all zero.
- R2: The output-data word (byte offset 0x00) and the output-enable word (0x04) hold bits 11:0, and bits 31:12 read as zero. `pad_out` carries the output-data bits and `pad_oe` carries the enable bits. A pin is driven only where its enable bit is 1.
- R3: The input word (0x08) returns the pad levels after a two-flop synchronizer. A pad change shows up at the second rising edge after it, not at the first. Writes to 0x08 have no effect.
- R4: Pins 0 to 7 take their polarity from the type word at 0x10, and pins 8 to 11 from the type word at 0x18. The polarity bit of pin p is bit 4*(p mod 8) of that word. A 1 there makes the pin active while low, and a 0 makes it active while high. The other bits of a pin's field do not affect polarity. Both type words hold all 32 bits.
- R5: The status word (0x0C) is write-one-to-clear. A written 1 clears its bit in that cycle, even if the pin is still active. A written 0 leaves the bit unchanged. A set bit stays set after the pin leaves its active level.
- R6: A status bit sets on the clock after the synchronized pin is seen at its active level, whatever the enable bit holds. If the pin is still active when the bit is cleared, the bit reads 1 again one cycle later.
- R7: The interrupt enable word (0x14) holds bits 11:0. `irq` is the OR over all pins of (status AND enable). With all enable bits at 0, `irq` stays low.
- R8: The mux-control word (0x1C) is a full 32-bit read/write value that appears on `mux_ctl`. Accesses whose byte address is not a multiple of four read zero and write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte address of the register |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pad_in | input | 12 | Pad levels, asynchronous to `clk` |
| pad_out | output | 12 | Output data driven to the pads |
| pad_oe | output | 12 | Per-pin output enable |
| mux_ctl | output | 32 | Stored mux-control word |
| irq | output | 1 | Combined interrupt, status AND enable, ORed over pins |

## Verification
The bench builds the block with its default parameters: twelve pins, a 32-bit data bus and a 5-bit byte address. With these values every pin reaches a type field. Pins 8 to 11 use the upper type word and pin 11 is the top status and enable bit, so the split polarity decode and the zero reads above bit 11 are both exercised. The bench also probes the one-cycle gap in which a cleared status bit reads zero before a still-active pin sets it again.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    // Word index (byte address bits 4:2). The order is the software-visible map.
    typedef enum logic [2:0] {
        REG_DOUT    = 3'd0,
        REG_DOE     = 3'd1,
        REG_DIN     = 3'd2,
        REG_STAT    = 3'd3,
        REG_TYPE_LO = 3'd4,
        REG_IEN     = 3'd5,
        REG_TYPE_HI = 3'd6,
        REG_MUX     = 3'd7
    } reg_idx_e;

    localparam int PINS_PER_TYPE = 8;
    localparam int TYPE_FIELD_W  = 4;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pad_i,
    output logic [WIDTH-1:0] lvl_o
);

    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.meta   = pad_i;
        s_d.stable = s_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign lvl_o = s_q.stable;

    // Warm-up counter so the latency check never looks before reset release.
    logic [1:0] warm_d, warm_q;
    always_comb warm_d = (warm_q == 2'd2) ? warm_q : warm_q + 2'd1;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) warm_q <= '0;
        else        warm_q <= warm_d;
    end

    // R3: the level seen inside lags the pad by exactly two edges
    p_sync_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> (lvl_o == $past(pad_i, 2)));

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
    parameter int NUM_PINS = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] lvl_i,
    input  logic [NUM_PINS-1:0] act_low_i,
    input  logic [NUM_PINS-1:0] ien_i,
    input  logic [NUM_PINS-1:0] clr_i,
    output logic [NUM_PINS-1:0] status_o,
    output logic                irq_o
);

    typedef struct packed {
        logic [NUM_PINS-1:0] status;
    } irq_state_t;

    irq_state_t st_d, st_q;
    logic [NUM_PINS-1:0] active;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pol
        assign active[p] = act_low_i[p] ? ~lvl_i[p] : lvl_i[p];
    end

    always_comb begin
        st_d        = st_q;
        // a write of one wins in its own cycle; an active pin re-arms next cycle
        st_d.status = (st_q.status | active) & ~clr_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o = st_q.status;
    assign irq_o    = |(st_q.status & ien_i);

    // R5: a bit written with one is zero the next cycle
    p_w1c_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_i) |=> ((status_o & $past(clr_i)) == '0));

    // R5: without a clear, a set bit never falls
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(status_o) & ~$past(clr_i) & ~status_o) == '0));

    // R6: an active, uncleared pin is latched on the next edge
    p_level_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(active & ~clr_i)) |=>
            ((status_o & $past(active & ~clr_i)) == $past(active & ~clr_i)));

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_pkg::*;
#(
    parameter int NUM_PINS = 12,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] lvl_i,
    input  logic [NUM_PINS-1:0] status_i,
    output logic [NUM_PINS-1:0] dout_o,
    output logic [NUM_PINS-1:0] doe_o,
    output logic [NUM_PINS-1:0] ien_o,
    output logic [NUM_PINS-1:0] act_low_o,
    output logic [NUM_PINS-1:0] clr_o,
    output logic [DATA_W-1:0]   mux_o
);

    localparam int IDX_LSB = 2;

    typedef struct packed {
        logic [NUM_PINS-1:0] dout;
        logic [NUM_PINS-1:0] doe;
        logic [NUM_PINS-1:0] ien;
        logic [DATA_W-1:0]   type_lo;
        logic [DATA_W-1:0]   type_hi;
        logic [DATA_W-1:0]   mux;
    } regs_t;

    regs_t    r_d, r_q;
    reg_idx_e idx;
    logic     hit;
    logic     wr;

    always_comb begin
        idx = reg_idx_e'(bus_addr[IDX_LSB +: 3]);
        hit = (bus_addr[IDX_LSB-1:0] == '0) && ((bus_addr >> (IDX_LSB + 3)) == '0);
        wr  = bus_we && hit;
    end

    always_comb begin
        r_d = r_q;
        if (wr) begin
            unique case (idx)
                REG_DOUT:    r_d.dout    = bus_wdata[NUM_PINS-1:0];
                REG_DOE:     r_d.doe     = bus_wdata[NUM_PINS-1:0];
                REG_IEN:     r_d.ien     = bus_wdata[NUM_PINS-1:0];
                REG_TYPE_LO: r_d.type_lo = bus_wdata;
                REG_TYPE_HI: r_d.type_hi = bus_wdata;
                REG_MUX:     r_d.mux     = bus_wdata;
                default:     r_d         = r_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (hit) begin
            unique case (idx)
                REG_DOUT:    bus_rdata[NUM_PINS-1:0] = r_q.dout;
                REG_DOE:     bus_rdata[NUM_PINS-1:0] = r_q.doe;
                REG_DIN:     bus_rdata[NUM_PINS-1:0] = lvl_i;
                REG_STAT:    bus_rdata[NUM_PINS-1:0] = status_i;
                REG_TYPE_LO: bus_rdata               = r_q.type_lo;
                REG_IEN:     bus_rdata[NUM_PINS-1:0] = r_q.ien;
                REG_TYPE_HI: bus_rdata               = r_q.type_hi;
                REG_MUX:     bus_rdata               = r_q.mux;
                default:     bus_rdata               = '0;
            endcase
        end
    end

    // polarity bit of pin p: bit 4*(p mod 8) of the low or high type word
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_type
        if (p < PINS_PER_TYPE) begin : g_lo
            assign act_low_o[p] = r_q.type_lo[TYPE_FIELD_W*p];
        end else begin : g_hi
            assign act_low_o[p] = r_q.type_hi[TYPE_FIELD_W*(p-PINS_PER_TYPE)];
        end
    end

    assign clr_o  = (wr && idx == REG_STAT) ? bus_wdata[NUM_PINS-1:0] : '0;
    assign dout_o = r_q.dout;
    assign doe_o  = r_q.doe;
    assign ien_o  = r_q.ien;
    assign mux_o  = r_q.mux;

    // R8: mux word only moves on a write to its own address
    p_mux_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && idx == REG_MUX) |=> (mux_o == $past(mux_o)));

    // R2: output enables only change through a write to their word
    p_doe_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && idx == REG_DOE) |=> (doe_o == $past(doe_o)));

endmodule

// File: rtl/gpio12_ctrl.sv
module gpio12_ctrl #(
    parameter int NUM_PINS = 12,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [DATA_W-1:0]   mux_ctl,
    output logic                irq
);

    logic [NUM_PINS-1:0] lvl;
    logic [NUM_PINS-1:0] status;
    logic [NUM_PINS-1:0] ien;
    logic [NUM_PINS-1:0] act_low;
    logic [NUM_PINS-1:0] clr;

    gpio_in_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pad_i (pad_in),
        .lvl_o (lvl)
    );

    gpio_regfile #(
        .NUM_PINS (NUM_PINS),
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .lvl_i     (lvl),
        .status_i  (status),
        .dout_o    (pad_out),
        .doe_o     (pad_oe),
        .ien_o     (ien),
        .act_low_o (act_low),
        .clr_o     (clr),
        .mux_o     (mux_ctl)
    );

    gpio_irq_unit #(.NUM_PINS(NUM_PINS)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl_i     (lvl),
        .act_low_i (act_low),
        .ien_i     (ien),
        .clr_i     (clr),
        .status_o  (status),
        .irq_o     (irq)
    );

    // R7: with every pin masked the line stays quiet
    p_masked_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == '0) |-> !irq);

    // R7: the line is never raised without a latched status bit
    p_irq_needs_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status != '0));

endmodule

// File: tb/tb_gpio12_ctrl.sv
`timescale 1ns/1ps
module tb_gpio12_ctrl;

    localparam int KIND_READ = 0;
    localparam int KIND_IRQ  = 1;
    localparam int KIND_OUT  = 2;
    localparam int KIND_OE   = 3;
    localparam int KIND_MUX  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [11:0] pad_in = '0;
    logic [11:0] pad_out;
    logic [11:0] pad_oe;
    logic [31:0] mux_ctl;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    int          q_kind[$];
    logic [31:0] q_exp[$];
    string       q_tag[$];

    always #4 clk = ~clk;

    gpio12_ctrl dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .mux_ctl   (mux_ctl),
        .irq       (irq)
    );

    // monitor: pops one expectation per falling edge and compares
    initial begin
        forever begin
            @(negedge clk);
            if (q_kind.size() > 0) begin
                int          k;
                logic [31:0] e;
                logic [31:0] got;
                string       t;
                k = q_kind.pop_front();
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                case (k)
                    KIND_READ: got = bus_rdata;
                    KIND_IRQ:  got = {31'd0, irq};
                    KIND_OUT:  got = {20'd0, pad_out};
                    KIND_OE:   got = {20'd0, pad_oe};
                    default:   got = mux_ctl;
                endcase
                checks++;
                if (got !== e) begin
                    errors++;
                    $display("FAIL %s: got %08h expected %08h", t, got, e);
                end
            end
        end
    end

    // driver: queue an expectation sampled in the current cycle
    task automatic expect_now(input int kind, input logic [4:0] addr,
                              input logic [31:0] exp, input string tag);
        bus_addr = addr;
        q_kind.push_back(kind);
        q_exp.push_back(exp);
        q_tag.push_back(tag);
        @(negedge clk);
        #1;
    endtask

    task automatic expect_next(input int kind, input logic [4:0] addr,
                               input logic [31:0] exp, input string tag);
        @(posedge clk);
        #1;
        expect_now(kind, addr, exp, tag);
    endtask

    // write lands on the second rising edge; returns 1 ns after it
    task automatic wr(input logic [4:0] addr, input logic [31:0] data);
        @(posedge clk);
        #1;
        bus_addr  = addr;
        bus_wdata = data;
        bus_we    = 1'b1;
        @(posedge clk);
        #1;
        bus_we    = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1: reset state
        for (int a = 0; a < 8; a++)
            expect_next(KIND_READ, 5'(a * 4), 32'h0, "R1 register reset");
        expect_next(KIND_IRQ, 5'h00, 32'h0, "R1 irq reset");
        expect_next(KIND_OUT, 5'h00, 32'h0, "R1 pad_out reset");
        expect_next(KIND_OE,  5'h00, 32'h0, "R1 pad_oe reset");
        expect_next(KIND_MUX, 5'h00, 32'h0, "R1 mux reset");

        // R2: output data and enable
        wr(5'h00, 32'hFFFF_FFFF);
        expect_next(KIND_READ, 5'h00, 32'h0000_0FFF, "R2 dout upper bits zero");
        expect_next(KIND_OUT,  5'h00, 32'h0000_0FFF, "R2 pad_out");
        wr(5'h04, 32'hFFFF_F0A5);
        expect_next(KIND_READ, 5'h04, 32'h0000_00A5, "R2 doe readback");
        expect_next(KIND_OE,   5'h04, 32'h0000_00A5, "R2 pad_oe");
        wr(5'h00, 32'h0000_0123);
        expect_next(KIND_OUT,  5'h00, 32'h0000_0123, "R2 pad_out second pattern");

        // R3: two-stage synchronizer latency and read-only input word
        @(posedge clk); #1;
        pad_in = 12'h3C5;
        expect_next(KIND_READ, 5'h08, 32'h0000_0000, "R3 input after one edge");
        expect_next(KIND_READ, 5'h08, 32'h0000_03C5, "R3 input after two edges");
        wr(5'h08, 32'h0000_0000);
        expect_next(KIND_READ, 5'h08, 32'h0000_03C5, "R3 write to input ignored");

        // clean up status from that pattern
        pad_in = 12'h000;
        idle(4);
        wr(5'h0C, 32'h0000_0FFF);
        expect_next(KIND_READ, 5'h0C, 32'h0, "R5 clear all");

        // R6: status latches while masked; R7 gating
        pad_in = 12'h008;
        idle(4);
        expect_next(KIND_READ, 5'h0C, 32'h0000_0008, "R6 latch while masked");
        expect_next(KIND_IRQ,  5'h0C, 32'h0, "R7 masked line low");
        wr(5'h14, 32'hFFFF_F008);
        expect_next(KIND_READ, 5'h14, 32'h0000_0008, "R7 enable readback");
        expect_next(KIND_IRQ,  5'h14, 32'h1, "R7 unmasked line high");

        // R5: zero writes leave status; clear of active pin re-sets (R6)
        wr(5'h0C, 32'h0000_0000);
        expect_next(KIND_READ, 5'h0C, 32'h0000_0008, "R5 write zero keeps bit");
        wr(5'h0C, 32'h0000_0008);
        expect_now (KIND_READ, 5'h0C, 32'h0000_0000, "R5 cleared in write cycle");
        expect_next(KIND_READ, 5'h0C, 32'h0000_0008, "R6 re-set while active");
        pad_in = 12'h000;
        idle(4);
        expect_next(KIND_READ, 5'h0C, 32'h0000_0008, "R5 sticky after pin drops");
        expect_next(KIND_IRQ,  5'h0C, 32'h1, "R7 line held by latch");
        wr(5'h0C, 32'h0000_0008);
        expect_now (KIND_READ, 5'h0C, 32'h0, "R5 clear inactive pin");
        expect_next(KIND_READ, 5'h0C, 32'h0, "R5 stays clear");
        expect_next(KIND_IRQ,  5'h0C, 32'h0, "R7 line drops");

        // R4: polarity in two type words
        wr(5'h10, 32'h0000_0010);
        expect_next(KIND_READ, 5'h10, 32'h0000_0010, "R4 low type readback");
        idle(3);
        expect_next(KIND_READ, 5'h0C, 32'h0000_0002, "R4 pin1 active low");
        wr(5'h18, 32'hFFFF_FFFE);
        expect_next(KIND_READ, 5'h18, 32'hFFFF_FFFE, "R4 high type full width");
        idle(3);
        wr(5'h0C, 32'h0000_0FFF);
        idle(2);
        expect_next(KIND_READ, 5'h0C, 32'h0000_0E02, "R4 only field bit0 sets polarity");
        pad_in = 12'h200;
        idle(4);
        wr(5'h0C, 32'h0000_0FFF);
        idle(2);
        expect_next(KIND_READ, 5'h0C, 32'h0000_0C02, "R4 pin9 high is inactive");

        // R7: mask selects which latched bit drives the line
        expect_next(KIND_IRQ, 5'h0C, 32'h0, "R7 enabled bit not latched");
        wr(5'h14, 32'h0000_0800);
        expect_next(KIND_IRQ, 5'h14, 32'h1, "R7 pin11 enabled");

        // R8: mux word and misaligned access
        wr(5'h1C, 32'hDEAD_BEEF);
        expect_next(KIND_READ, 5'h1C, 32'hDEAD_BEEF, "R8 mux readback");
        expect_next(KIND_MUX,  5'h1C, 32'hDEAD_BEEF, "R8 mux_ctl port");
        wr(5'h1D, 32'h1234_5678);
        expect_next(KIND_MUX,  5'h1C, 32'hDEAD_BEEF, "R8 misaligned write ignored");
        expect_next(KIND_READ, 5'h1D, 32'h0, "R8 misaligned read zero");

        idle(2);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule